// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen external request lines, ranks them, and drives a single interrupt request to a processor. Software sets it up through a small word-addressed register bus. For each source it picks one of four trigger styles: low level, high level, falling edge or rising edge. It also gives each source a priority byte, and only the low three bits of that byte count. A priority of zero keeps the source out of arbitration. Edge-style sources hold a sticky flag until software clears it with a command write that names the source.

The best pending source is found each cycle. The highest priority wins, and a tie goes to the lower source number. The request output rises only when the controller is switched on and that best priority is strictly above a programmable threshold. A status word reports the winning source number and its priority, together with an idle flag that reads 1 whenever no request is being raised. Request lines pass through a two-stage synchronizer before they are used.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Bit 0 of the word at offset 0x00 switches the controller on. While it is 0, `irq_out` stays low whatever the sources do.
- R2: Source n has a 2-bit trigger code in the word at 0x04 + 4*(n/8), at bits (n mod 8)*2 upward. The code reads back from the same place.
- R3: Source n has a priority byte in the word at 0x10 + 4*((n mod 16)/2), starting at bit (n/16)*16 + (n mod 2)*8. With sixteen sources the upper half of each such word stores nothing and reads 0.
- R4: Code 0 makes a source pending while its line is low, and code 1 while its line is high. Pending follows the line with no latching.
- R5: Code 2 latches a flag on a falling edge, and code 3 on a rising edge. The flag stays set after the line returns, and the opposite edge does not set it.
- R6: A write to 0x60 with bit 8 set clears the flag of the source numbered in bits 3:0. A write with bit 8 clear, or one naming another source, leaves the flag untouched.
- R7: The word at 0x80 returns the per-source pending bits (bit n = source n) before priority masking, threshold or enable.
- R8: A source whose priority byte has zero in its low three bits never wins and never raises `irq_out`.
- R9: `irq_out` is high only when the winning priority is strictly greater than bits 2:0 of the word at 0x40.
- R10: The status word at 0xA0 reports the winner's priority in bits 10:8 and its number in bits 4:0. The highest priority wins, ties go to the lowest number, and both fields read 0 when no source qualifies.
- R11: Bit 16 of the status word is 0 while `irq_out` is high and 1 otherwise, even when a winner is reported.
- R12: After a synchronous reset the enable, every trigger code, every priority byte and the threshold are all 0. A line held low is therefore seen as a pending low-level request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 16 | External request lines, asynchronous |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench checks the threshold compare at equality. A design that used greater-or-equal would raise the request with priority 5 against a threshold of 5. It sets two sources to the same priority: choosing the higher number would report vector 1 instead of 0. It writes a priority byte of 8, whose low three bits are zero; a design that tested the whole byte would let that source win. It drives the opposite edge in each edge mode, sends clear commands with the enable bit missing and with the wrong source number, and reads the status while the request is held back by the threshold. Each of these catches a design that latches on the wrong transition, clears too freely, or ties the idle flag to the winner instead of to the output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // register offsets
  localparam logic [7:0] OFS_ENABLE  = 8'h00;
  localparam logic [7:0] OFS_MODE0   = 8'h04;
  localparam logic [7:0] OFS_LVL0    = 8'h10;
  localparam logic [7:0] OFS_THRESH  = 8'h40;
  localparam logic [7:0] OFS_ECLR    = 8'h60;
  localparam logic [7:0] OFS_RAWPEND = 8'h80;
  localparam logic [7:0] OFS_STATUS  = 8'hA0;

  localparam int ECLR_GO_BIT   = 8;
  localparam int STAT_IDLE_BIT = 16;
  localparam int STAT_LVL_LSB  = 8;
  localparam int STAT_VEC_LSB  = 0;
  localparam int STAT_VEC_W    = 5;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  function automatic logic is_edge(input logic [1:0] code);
    return code[1];
  endfunction

  // line level that counts as a request for level codes
  function automatic logic level_on(input logic [1:0] code, input logic s);
    return (code == TRIG_LOW) ? ~s : s;
  endfunction

  // transition that counts as an event for edge codes
  function automatic logic edge_seen(input logic [1:0] code, input logic cur,
                                     input logic prev);
    return (code == TRIG_RISE) ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic int mode_word(input int n);
    return n / 8;
  endfunction

  function automatic int mode_lsb(input int n);
    return (n % 8) * 2;
  endfunction

  function automatic int lvl_word(input int n);
    return (n % 16) / 2;
  endfunction

  function automatic int lvl_lsb(input int n);
    return (n / 16) * 16 + (n % 2) * 8;
  endfunction

  function automatic logic [7:0] mode_addr(input int n);
    return OFS_MODE0 + 8'(4 * mode_word(n));
  endfunction

  function automatic logic [7:0] lvl_addr(input int n);
    return OFS_LVL0 + 8'(4 * lvl_word(n));
  endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int LVLW = 3,
  parameter int IDW  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [7:0]                 addr,
  input  logic                       wr_en,
  input  logic [31:0]                wdata,
  input  logic [NSRC-1:0]            raw_pend,
  input  logic [31:0]                status_word,
  output logic                       ctl_en,
  output logic [LVLW-1:0]            thr_q,
  output logic [NSRC-1:0][1:0]       mode_q,
  output logic [NSRC-1:0][LVLW-1:0]  lvl_eff,
  output logic                       clr_fire,
  output logic [IDW-1:0]             clr_id,
  output logic [31:0]                rdata
);

  logic [NSRC-1:0][7:0] lvl_byte;
  logic                 unused_wdata_sink;

  assign unused_wdata_sink = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en   <= 1'b0;
      thr_q    <= '0;
      mode_q   <= '0;
      lvl_byte <= '0;
    end else if (wr_en) begin
      if (addr == OFS_ENABLE) ctl_en <= wdata[0];
      if (addr == OFS_THRESH) thr_q  <= wdata[LVLW-1:0];
      for (int n = 0; n < NSRC; n++) begin
        if (addr == mode_addr(n)) mode_q[n]   <= wdata[mode_lsb(n) +: 2];
        if (addr == lvl_addr(n))  lvl_byte[n] <= wdata[lvl_lsb(n) +: 8];
      end
    end
  end

  // only the low bits of each priority byte take part in ranking
  always_comb begin
    for (int n = 0; n < NSRC; n++) lvl_eff[n] = lvl_byte[n][LVLW-1:0];
  end

  // edge clear is a command: it acts in the write cycle, nothing is stored
  assign clr_fire = wr_en && (addr == OFS_ECLR) && wdata[ECLR_GO_BIT];
  assign clr_id   = wdata[IDW-1:0];

  always_comb begin
    rdata = '0;
    if (addr == OFS_ENABLE)  rdata[0]         = ctl_en;
    if (addr == OFS_THRESH)  rdata[LVLW-1:0]  = thr_q;
    if (addr == OFS_RAWPEND) rdata[NSRC-1:0]  = raw_pend;
    if (addr == OFS_STATUS)  rdata            = status_word;
    for (int n = 0; n < NSRC; n++) begin
      if (addr == mode_addr(n)) rdata[mode_lsb(n) +: 2] = mode_q[n];
      if (addr == lvl_addr(n))  rdata[lvl_lsb(n) +: 8]  = lvl_byte[n];
    end
  end

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int IDW  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      lines,
  input  logic [NSRC-1:0][1:0] mode_q,
  input  logic                 clr_fire,
  input  logic [IDW-1:0]       clr_id,
  output logic [NSRC-1:0]      raw_pend,
  output logic [NSRC-1:0]      edge_flag,
  output logic [NSRC-1:0]      edge_set
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic s1, s2, s3, flag;
    logic set_now;

    // sync flops rest at 1 so the default low-active mode sees no request
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b1;
        s2   <= 1'b1;
        s3   <= 1'b1;
        flag <= 1'b0;
      end else begin
        s1 <= lines[g];
        s2 <= s1;
        s3 <= s2;
        // a fresh event wins over a clear in the same cycle
        if (set_now) flag <= 1'b1;
        else if (clr_fire && (clr_id == IDW'(g))) flag <= 1'b0;
      end
    end

    assign set_now      = is_edge(mode_q[g]) && edge_seen(mode_q[g], s2, s3);
    assign edge_set[g]  = set_now;
    assign edge_flag[g] = flag;
    assign raw_pend[g]  = is_edge(mode_q[g]) ? flag : level_on(mode_q[g], s2);
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NSRC = 16,
  parameter int LVLW = 3,
  parameter int IDW  = 4
) (
  input  logic [NSRC-1:0]           req,
  input  logic [NSRC-1:0][LVLW-1:0] lvl,
  output logic [IDW-1:0]            win_id,
  output logic [LVLW-1:0]           win_lvl
);

  // scan from the top down with >= so equal levels settle on the lowest number
  always_comb begin
    win_id  = '0;
    win_lvl = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (req[n] && (lvl[n] != '0) && (lvl[n] >= win_lvl)) begin
        win_lvl = lvl[n];
        win_id  = IDW'(n);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int LVLW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   irq_in,
  output logic              irq_out
);

  localparam int IDW = $clog2(NSRC);

  logic                      ctl_en;
  logic [LVLW-1:0]           thr_q;
  logic [NSRC-1:0][1:0]      mode_q;
  logic [NSRC-1:0][LVLW-1:0] lvl_eff;
  logic                      clr_fire;
  logic [IDW-1:0]            clr_id;
  logic [NSRC-1:0]           raw_pend;
  logic [NSRC-1:0]           edge_flag;
  logic [NSRC-1:0]           edge_set;
  logic [IDW-1:0]            win_id;
  logic [LVLW-1:0]           win_lvl;
  logic [31:0]               status_word;

  irqc_regs #(.NSRC(NSRC), .LVLW(LVLW), .IDW(IDW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .wr_en      (bus_we),
    .wdata      (bus_wdata),
    .raw_pend   (raw_pend),
    .status_word(status_word),
    .ctl_en     (ctl_en),
    .thr_q      (thr_q),
    .mode_q     (mode_q),
    .lvl_eff    (lvl_eff),
    .clr_fire   (clr_fire),
    .clr_id     (clr_id),
    .rdata      (bus_rdata)
  );

  irqc_detect #(.NSRC(NSRC), .IDW(IDW)) u_detect (
    .clk      (clk),
    .rst      (rst),
    .lines    (irq_in),
    .mode_q   (mode_q),
    .clr_fire (clr_fire),
    .clr_id   (clr_id),
    .raw_pend (raw_pend),
    .edge_flag(edge_flag),
    .edge_set (edge_set)
  );

  irqc_arbiter #(.NSRC(NSRC), .LVLW(LVLW), .IDW(IDW)) u_arb (
    .req    (raw_pend),
    .lvl    (lvl_eff),
    .win_id (win_id),
    .win_lvl(win_lvl)
  );

  assign irq_out = ctl_en && (win_lvl > thr_q);

  always_comb begin
    status_word = '0;
    status_word[STAT_IDLE_BIT]               = ~irq_out;
    status_word[STAT_LVL_LSB +: LVLW]        = win_lvl;
    status_word[STAT_VEC_LSB +: STAT_VEC_W]  = STAT_VEC_W'(win_id);
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSRC = 16,
  parameter int LVLW = 3,
  parameter int IDW  = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_en,
  input logic            irq_out,
  input logic [LVLW-1:0] thr_q,
  input logic [LVLW-1:0] win_lvl,
  input logic            clr_fire,
  input logic [IDW-1:0]  clr_id,
  input logic [NSRC-1:0] edge_set,
  input logic [NSRC-1:0] edge_flag
);

  assert_gate_off_R1: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |-> !irq_out);

  assert_above_thr_R9: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (win_lvl > thr_q));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (win_lvl != '0));

  assert_edge_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_set != '0) |=> ((edge_flag & $past(edge_set)) == $past(edge_set)));

  assert_clear_acts_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_fire && !edge_set[clr_id]) |=> !edge_flag[$past(clr_id)]);

  assert_drop_needs_clear_R6: assert property (@(posedge clk) disable iff (rst)
    ((~edge_flag & $past(edge_flag)) != '0) |-> $past(clr_fire));

endmodule

bind prio_irq_ctrl irqc_checker #(.NSRC(NSRC), .LVLW(LVLW), .IDW(IDW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctl_en   (ctl_en),
  .irq_out  (irq_out),
  .thr_q    (thr_q),
  .win_lvl  (win_lvl),
  .clr_fire (clr_fire),
  .clr_id   (clr_id),
  .edge_set (edge_set),
  .edge_flag(edge_flag)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;

  localparam logic [1:0] K_WR = 2'd0;  // register write
  localparam logic [1:0] K_LN = 2'd1;  // set lines, let them settle
  localparam logic [1:0] K_RD = 2'd2;  // read and compare
  localparam logic [1:0] K_IQ = 2'd3;  // compare irq_out with data[0]
  localparam int NSTEP = 59;

  // {kind, requirement, address, data}
  localparam logic [45:0] STEPS [NSTEP] = '{
    {K_WR, 4'd1,  8'h00, 32'h0000_0001},  // R1 switch on
    {K_WR, 4'd3,  8'h10, 32'h0000_0503},  // R3 src0=3 src1=5
    {K_RD, 4'd3,  8'h10, 32'h0000_0503},  // R3
    {K_LN, 4'd4,  8'h00, 32'h0000_FFFE},  // R4 src0 low
    {K_RD, 4'd7,  8'h80, 32'h0000_0001},  // R7
    {K_IQ, 4'd4,  8'h00, 32'h0000_0001},  // R4
    {K_RD, 4'd10, 8'hA0, 32'h0000_0300},  // R10
    {K_LN, 4'd10, 8'h00, 32'h0000_FFFC},  // src1 low too
    {K_RD, 4'd10, 8'hA0, 32'h0000_0501},  // R10 higher wins
    {K_WR, 4'd9,  8'h40, 32'h0000_0005},  // R9 threshold equal
    {K_IQ, 4'd9,  8'h00, 32'h0000_0000},  // R9
    {K_RD, 4'd11, 8'hA0, 32'h0001_0501},  // R11 idle with winner
    {K_WR, 4'd9,  8'h40, 32'h0000_0004},
    {K_IQ, 4'd9,  8'h00, 32'h0000_0001},  // R9
    {K_WR, 4'd1,  8'h00, 32'h0000_0000},
    {K_IQ, 4'd1,  8'h00, 32'h0000_0000},  // R1
    {K_RD, 4'd1,  8'hA0, 32'h0001_0501},  // R1
    {K_WR, 4'd1,  8'h00, 32'h0000_0001},
    {K_WR, 4'd10, 8'h10, 32'h0000_0505},  // tie
    {K_RD, 4'd10, 8'hA0, 32'h0000_0500},  // R10 lowest number
    {K_WR, 4'd8,  8'h10, 32'h0000_0008},  // R8 low bits zero
    {K_RD, 4'd7,  8'h80, 32'h0000_0003},  // R7 raw unmasked
    {K_IQ, 4'd8,  8'h00, 32'h0000_0000},  // R8
    {K_RD, 4'd8,  8'hA0, 32'h0001_0000},  // R8
    {K_LN, 4'd5,  8'h00, 32'h0000_FFFF},
    {K_WR, 4'd2,  8'h08, 32'h0000_000C},  // R2 src9 rising
    {K_RD, 4'd2,  8'h08, 32'h0000_000C},  // R2
    {K_WR, 4'd5,  8'h20, 32'h0000_0600},  // src9 level 6
    {K_WR, 4'd5,  8'h40, 32'h0000_0000},
    {K_LN, 4'd5,  8'h00, 32'h0000_FDFF},  // falling, ignored
    {K_RD, 4'd5,  8'h80, 32'h0000_0000},  // R5
    {K_LN, 4'd5,  8'h00, 32'h0000_FFFF},  // rising
    {K_RD, 4'd5,  8'h80, 32'h0000_0200},  // R5
    {K_RD, 4'd10, 8'hA0, 32'h0000_0609},  // R10
    {K_LN, 4'd5,  8'h00, 32'h0000_FDFF},
    {K_RD, 4'd5,  8'h80, 32'h0000_0200},  // R5 held
    {K_WR, 4'd6,  8'h60, 32'h0000_0009},  // no go bit
    {K_RD, 4'd6,  8'h80, 32'h0000_0200},  // R6
    {K_WR, 4'd6,  8'h60, 32'h0000_0109},
    {K_RD, 4'd6,  8'h80, 32'h0000_0000},  // R6
    {K_IQ, 4'd6,  8'h00, 32'h0000_0000},  // R6
    {K_WR, 4'd5,  8'h08, 32'h0000_0008},  // src9 falling
    {K_LN, 4'd5,  8'h00, 32'h0000_FFFF},
    {K_RD, 4'd5,  8'h80, 32'h0000_0000},  // R5
    {K_LN, 4'd5,  8'h00, 32'h0000_FDFF},
    {K_RD, 4'd5,  8'h80, 32'h0000_0200},  // R5
    {K_WR, 4'd6,  8'h60, 32'h0000_0108},  // wrong source
    {K_RD, 4'd6,  8'h80, 32'h0000_0200},  // R6
    {K_WR, 4'd6,  8'h60, 32'h0000_0109},
    {K_RD, 4'd6,  8'h80, 32'h0000_0000},  // R6
    {K_WR, 4'd2,  8'h08, 32'h0000_4008},  // src15 high-active
    {K_RD, 4'd2,  8'h08, 32'h0000_4008},  // R2
    {K_WR, 4'd3,  8'h2C, 32'hFFFF_0700},
    {K_RD, 4'd3,  8'h2C, 32'h0000_0700},  // R3 upper half empty
    {K_RD, 4'd4,  8'h80, 32'h0000_8000},  // R4
    {K_RD, 4'd10, 8'hA0, 32'h0000_070F},  // R10
    {K_LN, 4'd4,  8'h00, 32'h0000_7DFF},
    {K_RD, 4'd4,  8'h80, 32'h0000_0000},  // R4
    {K_IQ, 4'd4,  8'h00, 32'h0000_0000}   // R4
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = 16'hFFFF;
  logic        irq_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_in   (irq_in),
    .irq_out  (irq_out)
  );

  task automatic note(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    bus_addr = a;
    #1;
    note(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input int req);
    @(negedge clk);
    #1;
    note(req, {31'b0, irq_out}, {31'b0, exp});
  endtask

  task automatic lines(input logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12 reset state, lines idle high
    rd_chk(8'h00, 32'h0, 12);
    rd_chk(8'h04, 32'h0, 12);
    rd_chk(8'h08, 32'h0, 12);
    rd_chk(8'h10, 32'h0, 12);
    rd_chk(8'h2C, 32'h0, 12);
    rd_chk(8'h40, 32'h0, 12);
    rd_chk(8'h80, 32'h0, 12);
    rd_chk(8'hA0, 32'h0001_0000, 12);
    irq_chk(1'b0, 12);

    for (int i = 0; i < NSTEP; i++) begin
      case (STEPS[i][45:44])
        K_WR: wr(STEPS[i][39:32], STEPS[i][31:0]);
        K_LN: lines(STEPS[i][15:0]);
        K_RD: rd_chk(STEPS[i][39:32], STEPS[i][31:0], int'(STEPS[i][43:40]));
        default: irq_chk(STEPS[i][0], int'(STEPS[i][43:40]));
      endcase
    end

    // R12 second reset with sources 9 and 15 held low: defaults are low-active
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_chk(8'h08, 32'h0, 12);
    rd_chk(8'h2C, 32'h0, 12);
    rd_chk(8'h00, 32'h0, 12);
    repeat (5) @(negedge clk);
    rd_chk(8'h80, 32'h0000_8200, 12);
    rd_chk(8'hA0, 32'h0001_0000, 12);
    irq_chk(1'b0, 12);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule